// File: doc/BRIEF.md
# Dual-Threshold Interval Timer

This block is a single up-counter that measures two elapsed intervals from one restart event. A sequencing controller pulses or holds a start input whenever it changes state. The counter is then cleared to zero and armed. It advances once per clock and raises a short-interval flag and then a long-interval flag as the count passes two configured thresholds. When the long threshold is reached the counter stops and both flags stay high until the next start.

The controller may drive start from a register, so that start arrives one clock after its state change, or from combinational logic, so that start arrives in the same cycle. A build-time parameter picks how start takes effect on the flags. In the synchronous mode the flags drop after the next rising edge. In the immediate mode they drop in the same cycle that start is seen. In both modes the register itself is cleared at the clock edge. The count width is derived from the long threshold, so the counter never wraps.

Top module: `dual_span_timer`

## Requirements
- R1: While rst_n is low at a rising edge, the timer returns to idle: count zero, not armed, both flags low. Without a start it stays idle and both flags stay low.
- R2: After a rising edge that samples start_i high and then no further start, short_done_o is high exactly from the SHORT_LEN-th following rising edge onward.
- R3: After a rising edge that samples start_i high and then no further start, long_done_o is high exactly from the LONG_LEN-th following rising edge onward.
- R4: long_done_o is never high while short_done_o is low.
- R5: Once long_done_o is high, the count freezes and both flags stay high for any number of cycles until start_i is next asserted.
- R6: With CLR_MODE = CLR_SYNC (encoding 0), asserting start_i leaves both flags at their previous values during that cycle. They take the cleared value only after the rising edge.
- R7: With CLR_MODE = CLR_ASYNC (encoding 1), both flags are low in every cycle in which start_i is high.
- R8: A start sampled at the same edge where the count would reach LONG_LEN takes priority: the count restarts from zero and keeps counting.
- R9: While start_i is held high over several edges, the count stays at zero. Counting starts at the first edge that samples start_i low, so R2 and R3 are measured from the last edge with start high.
- R10: A start given at any point within an interval restarts the timing, and the earlier progress has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Restart request: clears the count and arms counting |
| short_done_o | output | 1 | High while the count is at or above SHORT_LEN |
| long_done_o | output | 1 | High while the count is at or above LONG_LEN |

## Verification
Two instances of a small configuration (short 3, long 7) run side by side, one in each clear mode. They are driven with one-cycle starts, starts held for one to four cycles, and restarts at every offset from zero to past the long threshold. A start that lands just as the long count is reached separates start priority from freeze priority. Comparing the two instances in each start cycle separates the synchronous clear from the immediate clear. Long idle stretches after the long flag show whether the count wraps or the flags decay.

// File: rtl/dst_pkg.sv
// Shared definitions for the dual-threshold interval timer.
// Assumes nothing beyond IEEE 1800-2017 elaboration of constant functions.
package dst_pkg;

    // How a start request reaches the threshold flags.
    typedef enum logic {
        CLR_SYNC  = 1'b0,   // flags follow the register; clear seen after the edge
        CLR_ASYNC = 1'b1    // flags forced low in the same cycle as start
    } clr_mode_e;

    // Bits needed to hold every value from 0 up to and including lim.
    function automatic int cnt_width(input int lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/dst_arm.sv
// Arming flag for the interval counter.
// Set by a start request and cleared once the counter is about to reach its
// limit, so counting stops by itself. Assumes start has priority over the
// limit event within one cycle.
module dst_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic reach_i,
    output logic run_o
);

    // Purpose: hold the enable that lets the counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o <= 1'b0;
        end else if (start_i) begin
            run_o <= 1'b1;
        end else if (reach_i) begin
            run_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dst_counter.sv
// Saturating up-counter for the interval timer.
// Clears to zero at any edge with start high and advances by one per edge while
// armed. It never goes past LIMIT. reach_o tells the arming logic that this
// edge will land on LIMIT. Assumes LIMIT fits in CW bits and LIMIT >= 2.
module dst_counter #(
    parameter int LIMIT = 7,
    parameter int CW    = dst_pkg::cnt_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o,
    output logic          reach_o
);

    localparam logic [CW-1:0] TOP      = CW'(LIMIT);
    localparam logic [CW-1:0] TOP_LESS = CW'(LIMIT - 1);

    logic adv;

    // Purpose: decide whether this edge advances the count.
    always_comb begin
        adv     = run_i && (cnt_o != TOP);
        reach_o = adv && (cnt_o == TOP_LESS) && !start_i;
    end

    // Purpose: count register with start priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (start_i) begin
            cnt_o <= '0;
        end else if (adv) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/dst_thresh.sv
// Threshold comparators for the interval timer.
// Turns the count into the short and long flags. In the immediate clear mode a
// high start masks the count to zero in the same cycle, which gives the clear
// without using start as a reset on any flop. Assumes SHORT_LEN >= 1 and
// SHORT_LEN < LONG_LEN.
module dst_thresh #(
    parameter int               SHORT_LEN = 3,
    parameter int               LONG_LEN  = 7,
    parameter dst_pkg::clr_mode_e CLR_MODE = dst_pkg::CLR_SYNC,
    parameter int               CW        = dst_pkg::cnt_width(LONG_LEN)
) (
    input  logic [CW-1:0] cnt_i,
    input  logic          start_i,
    output logic          short_o,
    output logic          long_o
);

    localparam logic [CW-1:0] SHORT_T = CW'(SHORT_LEN);
    localparam logic [CW-1:0] LONG_T  = CW'(LONG_LEN);

    logic [CW-1:0] seen;

    generate
        if (CLR_MODE == dst_pkg::CLR_ASYNC) begin : g_imm
            // Purpose: a high start hides the stored count at once.
            always_comb seen = start_i ? '0 : cnt_i;
        end else begin : g_sync
            // Purpose: flags follow the stored count only.
            always_comb seen = cnt_i;
        end
    endgenerate

    // Purpose: compare the visible count with both thresholds.
    always_comb begin
        short_o = (seen >= SHORT_T);
        long_o  = (seen >= LONG_T);
    end

endmodule

// File: rtl/dual_span_timer.sv
// Dual-threshold interval timer.
// One counter gives a short and a long terminal flag. A start request clears and
// arms it, and it freezes at the long count. CLR_MODE picks whether start clears
// the flags after the edge or in the same cycle. Assumes 1 <= SHORT_LEN <
// LONG_LEN and a single clock domain with start synchronous to clk.
module dual_span_timer #(
    parameter int                 SHORT_LEN = 3,
    parameter int                 LONG_LEN  = 7,
    parameter dst_pkg::clr_mode_e CLR_MODE  = dst_pkg::CLR_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic short_done_o,
    output logic long_done_o
);

    localparam int CW = dst_pkg::cnt_width(LONG_LEN);

    logic          run;
    logic          reach;
    logic [CW-1:0] cnt;

    dst_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .reach_i (reach),
        .run_o   (run)
    );

    dst_counter #(
        .LIMIT (LONG_LEN),
        .CW    (CW)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .run_i   (run),
        .cnt_o   (cnt),
        .reach_o (reach)
    );

    dst_thresh #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .CLR_MODE  (CLR_MODE),
        .CW        (CW)
    ) u_thr (
        .cnt_i   (cnt),
        .start_i (start_i),
        .short_o (short_done_o),
        .long_o  (long_done_o)
    );

endmodule

// File: rtl/dst_checker.sv
// Assertion checker for dual_span_timer, attached by bind.
// Keeps its own edge count since the last start, taken from the requirements,
// and relates the flags to it.
module dst_checker #(
    parameter int                 SHORT_LEN = 3,
    parameter int                 LONG_LEN  = 7,
    parameter dst_pkg::clr_mode_e CLR_MODE  = dst_pkg::CLR_SYNC
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic short_done_o,
    input logic long_done_o
);

    localparam int CW = dst_pkg::cnt_width(LONG_LEN);

    logic [CW-1:0] since;
    logic          armed;
    logic          exp_s;
    logic          exp_l;

    // Purpose: count edges since the last start, saturating at the long length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
            armed <= 1'b0;
        end else if (start_i) begin
            since <= '0;
            armed <= 1'b1;
        end else if (armed && (since < CW'(LONG_LEN))) begin
            since <= since + 1'b1;
        end
    end

    always_comb begin
        exp_s = armed && (since >= CW'(SHORT_LEN));
        exp_l = armed && (since >= CW'(LONG_LEN));
    end

    assert_ts_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |-> (short_done_o == exp_s));

    assert_tl_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |-> (long_done_o == exp_l));

    assert_tl_implies_ts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        long_done_o |-> short_done_o);

    assert_long_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (long_done_o && !start_i) |=> (long_done_o || start_i));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !long_done_o);

    generate
        if (CLR_MODE == dst_pkg::CLR_ASYNC) begin : g_imm
            assert_async_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
                start_i |-> (!short_done_o && !long_done_o));
        end else begin : g_sync
            assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                start_i |-> ((short_done_o == exp_s) && (long_done_o == exp_l)));
        end
    endgenerate

endmodule

bind dual_span_timer dst_checker #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .CLR_MODE  (CLR_MODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .short_done_o (short_done_o),
    .long_done_o  (long_done_o)
);

// File: tb/sim_dual_span_timer.sv
`timescale 1ns/1ps
// Bench: a synchronous and an immediate-clear instance side by side, swept
// over start widths and restart offsets, against an arithmetic edge count.
module sim_dual_span_timer;

    localparam int SH = 3;
    localparam int LG = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ts0, tl0, ts1, tl1;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Expected state from the requirements: edges since the last start.
    int m_cnt = 0;
    bit m_arm = 1'b0;

    always #4 clk = ~clk;

    dual_span_timer #(.SHORT_LEN(SH), .LONG_LEN(LG), .CLR_MODE(dst_pkg::CLR_SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .short_done_o(ts0), .long_done_o(tl0));

    dual_span_timer #(.SHORT_LEN(SH), .LONG_LEN(LG), .CLR_MODE(dst_pkg::CLR_ASYNC)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .short_done_o(ts1), .long_done_o(tl1));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_cnt <= 0;
            m_arm <= 1'b0;
        end else if (start) begin
            m_cnt <= 0;
            m_arm <= 1'b1;
        end else if (m_arm && m_cnt < LG) begin
            m_cnt <= m_cnt + 1;
        end
    end

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s t=%0t actual=%b expected=%b", req, what, $time, got, exp);
        end
    endtask

    // One cycle: drive start, compare mid-cycle, then move past the next edge.
    task automatic cyc(input logic st, input string tag_s, input string tag_l);
        logic es, el;
        start = st;
        #3;
        es = m_arm && (m_cnt >= SH);
        el = m_arm && (m_cnt >= LG);
        if (st) begin
            check("R6", "sync short", ts0, es);
            check("R6", "sync long", tl0, el);
            check("R7", "imm short", ts1, 1'b0);
            check("R7", "imm long", tl1, 1'b0);
        end else begin
            check(tag_s, "sync short", ts0, es);
            check(tag_l, "sync long", tl0, el);
            check(tag_s, "imm short", ts1, es);
            check(tag_l, "imm long", tl1, el);
        end
        check("R4", "sync order", (tl0 && !ts0), 1'b0);
        check("R4", "imm order", (tl1 && !ts1), 1'b0);
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 20000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired");
                summary();
            end
        end
    end

    initial begin
        @(posedge clk);
        #1;
        // R1: reset state and idle without a start
        for (int i = 0; i < 3; i++) cyc(1'b0, "R1", "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) cyc(1'b0, "R1", "R1");
        // R2 / R3: one-cycle start, full interval
        cyc(1'b1, "R2", "R3");
        for (int i = 0; i < LG + 3; i++) cyc(1'b0, "R2", "R3");
        // R5: frozen at the long count
        for (int i = 0; i < 25; i++) cyc(1'b0, "R5", "R5");
        // R6 / R7: start while both flags are high
        cyc(1'b1, "R6", "R6");
        for (int i = 0; i < LG + 2; i++) cyc(1'b0, "R2", "R3");
        // R10 / R8: restart at every offset; offset LG-1 lands on the long edge
        for (int d = 0; d <= LG + 1; d++) begin
            cyc(1'b1, "R10", "R10");
            for (int i = 0; i < d; i++)
                cyc(1'b0, (d == LG - 1) ? "R8" : "R10", (d == LG - 1) ? "R8" : "R10");
        end
        for (int i = 0; i < LG + 2; i++) cyc(1'b0, "R8", "R8");
        // R9: start held for several cycles
        for (int w = 1; w <= 4; w++) begin
            for (int i = 0; i < w; i++) cyc(1'b1, "R9", "R9");
            for (int i = 0; i < LG + 2; i++) cyc(1'b0, "R9", "R9");
        end
        // R1: reset in the middle of an interval returns to idle
        cyc(1'b1, "R1", "R1");
        for (int i = 0; i < SH + 1; i++) cyc(1'b0, "R1", "R1");
        rst_n = 1'b0;
        cyc(1'b0, "R1", "R1");
        rst_n = 1'b1;
        for (int i = 0; i < LG + 2; i++) cyc(1'b0, "R1", "R1");
        summary();
    end

endmodule